// File: doc/BRIEF.md
# SDRAM read-run idle state sequencer

This block steps an external bus through its access states for two kinds of address space: a synchronous DRAM region and a plain asynchronous region. For each accepted request it emits one state per clock, the SDRAM command for that state and a busy flag. A read that opens a new DRAM row runs precharge-all, activate, column read, a CAS-latency wait and a closing state. A read that lands in the row left open by the previous DRAM access runs only the column part. An asynchronous-space access takes three plain states.

Between back-to-back accesses the sequencer can place one or two idle states. Two condition bits select when idle states are wanted: a change of area, or a read followed by a write. A length bit selects one or two idle states. Idle after a DRAM read is also gated by its own master enable. When that enable is clear, the condition bits are ignored for accesses that follow a DRAM read.

Requests arrive on a valid/ready stream. A request must stay stable while `req_valid` is high and `req_ready` is low. It is taken on the first rising edge where both are high. `req_ready` is high only in the bus-idle state, in a closing state (Tc2, T3) when no idle state is needed, and in the last idle state. The configuration inputs are plain pins. They are looked at only in the cycle where the next access is decided.

Top module: `sdram_idle_seq`

## Requirements
- R1: After reset the state code is 0 (bus idle), the command is NOP (0), `bus_busy` is 0 and `req_ready` is 1.
- R2: A DRAM-space request with no matching open row produces state codes 1 (Tp), 2 (Tr), 3 (Tc1), 4 (Tcl), 5 (Tc2) on consecutive clocks. The matching commands are PALL (1), ACTV (2), READ (3), NOP (0), NOP (0).
- R3: A DRAM-space request whose row equals the row of the last DRAM access goes straight to Tc1, Tcl, Tc2 (codes 3, 4, 5).
- R4: An asynchronous-space request produces codes 6 (T1), 7 (T2), 8 (T3) with the command held at NOP.
- R5: When `cfg_sdram_idle_en` is 0, no idle state follows a DRAM read, whatever `cfg_idle_cond` holds.
- R6: With the enable at 1, `cfg_idle_cond[0]` at 1 and `cfg_idle_len` at 0, exactly one idle state (code 9, command NOP) lies between a DRAM read and a following access to a different area.
- R7: With `cfg_idle_len` at 1, two idle states are inserted instead of one.
- R8: `cfg_idle_cond[1]` inserts idle states when a read is followed by a write. A read followed by a read to the same area gets no idle states.
- R9: `bus_busy` is 0 only in the bus-idle state, Tc2, T3 and the last idle state. `req_ready` is never high while `bus_busy` is high, so a request that arrives during idle states waits until the last one.
- R10: The idle decision and idle length are taken from the configuration in the closing state. Changing the configuration during the idle states does not alter their number.
- R11: If no request is valid in a closing state or in the last idle state, the next state is bus idle (code 0).
- R12: After an asynchronous read, the condition bits apply whatever the DRAM enable holds.
- R13: `bus_addr` carries the row (zero-extended) in Tr, the column (zero-extended) in Tc1, and {row, column} in T1 to T3. It is zero in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_sdram | input | 1 | 1 = DRAM space, 0 = asynchronous space |
| req_area | input | AREA_W | Area number |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_sdram_idle_en | input | 1 | Master enable for idle after a DRAM read |
| cfg_idle_cond | input | 2 | Bit 0: area change; bit 1: read then write |
| cfg_idle_len | input | 1 | 0 = one idle state, 1 = two |
| st_code | output | 4 | Current state code |
| cmd_code | output | 2 | 0 NOP, 1 PALL, 2 ACTV, 3 READ |
| bus_busy | output | 1 | Access in progress and not at a hand-over point |
| bus_addr | output | ROW_W+COL_W | Address for the current state |

## Verification
On every clock, the assertions check the command ordering (PALL then ACTV then READ then a latency NOP). They also check that `req_ready` never rises while `bus_busy` is high, that idle states drive NOP, and that the first of two idle states refuses requests. The scenarios show what needs a whole request history: the row-hit shortcut, how many idle states appear under each mix of enable, condition and length bits, the sampling of the configuration at the decision point, and the address carried in each state.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0, ST_TP = 4'd1, ST_TR = 4'd2, ST_TC1 = 4'd3, ST_TCL = 4'd4,
    ST_TC2 = 4'd5, ST_T1 = 4'd6, ST_T2 = 4'd7, ST_T3 = 4'd8, ST_TI = 4'd9
  } bus_st_e;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0, CMD_PALL = 2'd1, CMD_ACTV = 2'd2, CMD_READ = 2'd3
  } dram_cmd_e;
endpackage

// File: rtl/sis_idle_rule.sv
module sis_idle_rule #(
  parameter int AREA_W = 3
) (
  input  logic              last_sdram,
  input  logic              last_write,
  input  logic [AREA_W-1:0] last_area,
  input  logic [AREA_W-1:0] next_area,
  input  logic              next_write,
  input  logic              dram_en,
  input  logic [1:0]        cond,
  output logic              need_idle
);
  logic gate;
  logic hit;
  always_comb begin
    // a DRAM read is gated by its own enable; other reads go straight to cond
    gate = !last_write && (last_sdram ? dram_en : 1'b1);
    hit  = (cond[0] && (last_area != next_area)) || (cond[1] && next_write);
    need_idle = gate && hit;
  end
endmodule

// File: rtl/sis_row_track.sv
module sis_row_track #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ROW_W-1:0] load_row,
  input  logic [ROW_W-1:0] probe_row,
  output logic             row_hit
);
  logic [ROW_W-1:0] open_row;
  logic             open_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_vld <= 1'b0;
      open_row <= '0;
    end else if (load) begin
      open_vld <= 1'b1;
      open_row <= load_row;
    end
  end

  assign row_hit = open_vld && (open_row == probe_row);
endmodule

// File: rtl/sis_cmd_dec.sv
module sis_cmd_dec
  import sis_pkg::*;
(
  input  bus_st_e   st,
  input  logic      ti_last,
  output dram_cmd_e cmd,
  output logic      busy
);
  always_comb begin
    unique case (st)
      ST_TP:   cmd = CMD_PALL;
      ST_TR:   cmd = CMD_ACTV;
      ST_TC1:  cmd = CMD_READ;
      default: cmd = CMD_NOP;
    endcase
    unique case (st)
      ST_IDLE, ST_TC2, ST_T3: busy = 1'b0;
      ST_TI:                  busy = !ti_last;
      default:                busy = 1'b1;
    endcase
  end
endmodule

// File: rtl/sdram_idle_seq.sv
module sdram_idle_seq
  import sis_pkg::*;
#(
  parameter int AREA_W = 3,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_sdram,
  input  logic [AREA_W-1:0]      req_area,
  input  logic [ROW_W-1:0]       req_row,
  input  logic [COL_W-1:0]       req_col,
  input  logic                   req_write,
  input  logic                   cfg_sdram_idle_en,
  input  logic [1:0]             cfg_idle_cond,
  input  logic                   cfg_idle_len,
  output logic [3:0]             st_code,
  output logic [1:0]             cmd_code,
  output logic                   bus_busy,
  output logic [ROW_W+COL_W-1:0] bus_addr
);
  localparam int ADDR_W = ROW_W + COL_W;

  bus_st_e           st, st_nx;
  dram_cmd_e         cmd;
  logic              ti_more;
  logic              ti_last;
  logic              closing;
  logic              need_idle;
  logic              row_hit;
  logic              take;
  logic              cur_sdram, cur_write;
  logic [AREA_W-1:0] cur_area;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;

  assign closing = (st == ST_TC2) || (st == ST_T3);
  assign ti_last = (st == ST_TI) && !ti_more;

  sis_idle_rule #(.AREA_W(AREA_W)) u_rule (
    .last_sdram(cur_sdram), .last_write(cur_write), .last_area(cur_area),
    .next_area(req_area), .next_write(req_write),
    .dram_en(cfg_sdram_idle_en), .cond(cfg_idle_cond), .need_idle(need_idle)
  );

  sis_row_track #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst(rst), .load(take && req_sdram), .load_row(req_row),
    .probe_row(req_row), .row_hit(row_hit)
  );

  sis_cmd_dec u_dec (.st(st), .ti_last(ti_last), .cmd(cmd), .busy(bus_busy));

  // hand-over points: bus idle, closing state with no idle owed, last idle state
  assign req_ready = (st == ST_IDLE) || (closing && !need_idle) || ti_last;
  assign take      = req_valid && req_ready;

  function automatic bus_st_e first_state(input logic sdram, input logic hit);
    if (!sdram)   return ST_T1;
    else if (hit) return ST_TC1;
    else          return ST_TP;
  endfunction

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (take) st_nx = first_state(req_sdram, row_hit);
      ST_TP:   st_nx = ST_TR;
      ST_TR:   st_nx = ST_TC1;
      ST_TC1:  st_nx = ST_TCL;
      ST_TCL:  st_nx = ST_TC2;
      ST_T1:   st_nx = ST_T2;
      ST_T2:   st_nx = ST_T3;
      ST_TC2, ST_T3: begin
        if (req_valid && need_idle) st_nx = ST_TI;
        else if (take)              st_nx = first_state(req_sdram, row_hit);
        else                        st_nx = ST_IDLE;
      end
      ST_TI: begin
        if (ti_more)   st_nx = ST_TI;
        else if (take) st_nx = first_state(req_sdram, row_hit);
        else           st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ti_more   <= 1'b0;
      cur_sdram <= 1'b0;
      cur_write <= 1'b0;
      cur_area  <= '0;
      cur_row   <= '0;
      cur_col   <= '0;
    end else begin
      st <= st_nx;
      if (closing && req_valid && need_idle) ti_more <= cfg_idle_len;
      else if (st == ST_TI)                  ti_more <= 1'b0;
      if (take) begin
        cur_sdram <= req_sdram;
        cur_write <= req_write;
        cur_area  <= req_area;
        cur_row   <= req_row;
        cur_col   <= req_col;
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_TR:              bus_addr = ADDR_W'(cur_row);
      ST_TC1:             bus_addr = ADDR_W'(cur_col);
      ST_T1, ST_T2, ST_T3: bus_addr = {cur_row, cur_col};
      default:            bus_addr = '0;
    endcase
  end

  assign st_code  = st;
  assign cmd_code = cmd;

  // R2: precharge is followed by activate, activate by column read, read by latency wait
  p_pall_actv_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_code == CMD_PALL |=> cmd_code == CMD_ACTV);
  p_actv_read_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_code == CMD_ACTV |=> cmd_code == CMD_READ);
  p_read_wait_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_code == CMD_READ |=> (st_code == ST_TCL && cmd_code == CMD_NOP));
  // R6: idle states drive no command
  p_ti_nop_r6: assert property (@(posedge clk) disable iff (rst)
    st_code == ST_TI |-> cmd_code == CMD_NOP);
  // R9: no hand-over while busy; first of two idle states refuses requests
  p_ready_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_busy);
  p_hold_in_ti_r9: assert property (@(posedge clk) disable iff (rst)
    (st_code == ST_TI && bus_busy) |-> (!req_ready && st_nx == ST_TI));
endmodule

// File: tb/sim_sdram_idle_seq.sv
`timescale 1ns/1ps
module sim_sdram_idle_seq;
  localparam int AREA_W = 3, ROW_W = 13, COL_W = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_sdram = 1'b0, req_write = 1'b0;
  logic [AREA_W-1:0] req_area = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic cfg_en = 1'b0, cfg_len = 1'b0;
  logic [1:0] cfg_cond = 2'b00;
  logic [3:0] st_code;
  logic [1:0] cmd_code;
  logic bus_busy;
  logic [ROW_W+COL_W-1:0] bus_addr;

  int errors = 0, checks = 0;
  logic rec = 1'b0;
  int tidx = 0;
  logic [3:0] st_tr [64];
  logic [1:0] cmd_tr [64];
  logic       busy_tr [64];
  logic [ROW_W+COL_W-1:0] addr_tr [64];

  always #2.5 clk = ~clk;

  sdram_idle_seq #(.AREA_W(AREA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_sdram(req_sdram), .req_area(req_area), .req_row(req_row),
    .req_col(req_col), .req_write(req_write), .cfg_sdram_idle_en(cfg_en),
    .cfg_idle_cond(cfg_cond), .cfg_idle_len(cfg_len), .st_code(st_code),
    .cmd_code(cmd_code), .bus_busy(bus_busy), .bus_addr(bus_addr)
  );

  always @(posedge clk) begin
    #1;
    if (rec && tidx < 64) begin
      st_tr[tidx] = st_code; cmd_tr[tidx] = cmd_code;
      busy_tr[tidx] = bus_busy; addr_tr[tidx] = bus_addr;
      tidx = tidx + 1;
    end
  end

  task automatic chk(input longint act, input longint exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_st(input logic [63:0] exp, input int n, input string req);
    for (int i = 0; i < n; i++)
      chk(st_tr[i], (exp >> (4 * (n - 1 - i))) & 64'hF, req, $sformatf("state[%0d]", i));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tidx = 0; rec = 1'b1;
  endtask

  task automatic issue(input logic sd, input int area, input int row, input int col, input logic wr);
    req_sdram = sd; req_area = AREA_W'(area); req_row = ROW_W'(row);
    req_col = COL_W'(col); req_write = wr; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    repeat (6) @(negedge clk);
    rec = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(); rec = 1'b0; #1;
    chk(st_code, 0, "R1", "state"); chk(cmd_code, 0, "R1", "cmd");
    chk(bus_busy, 0, "R1", "busy"); chk(req_ready, 1, "R1", "ready");
  endtask

  task automatic t_new_row();
    cfg_en = 1; cfg_cond = 2'b11; cfg_len = 0;
    do_reset(); issue(1, 1, 5, 7, 0); finish_run();
    check_st(64'h123450, 6, "R2");
    chk(cmd_tr[0], 1, "R2", "cmd Tp"); chk(cmd_tr[1], 2, "R2", "cmd Tr");
    chk(cmd_tr[2], 3, "R2", "cmd Tc1"); chk(cmd_tr[3], 0, "R2", "cmd Tcl");
    chk(cmd_tr[4], 0, "R2", "cmd Tc2");
    chk(st_tr[5], 0, "R11", "idle after lone access");
  endtask

  task automatic t_same_row();
    cfg_en = 1; cfg_cond = 2'b11; cfg_len = 0;
    do_reset(); issue(1, 2, 9, 11, 0); issue(1, 2, 9, 12, 0); finish_run();
    check_st(64'h123453450, 9, "R3");
    chk(addr_tr[1], 9, "R13", "row in Tr");
    chk(addr_tr[2], 11, "R13", "col1 in Tc1");
    chk(addr_tr[5], 12, "R13", "col2 in Tc1");
    chk(addr_tr[4], 0, "R13", "zero in Tc2");
  endtask

  task automatic t_normal();
    do_reset(); issue(0, 3, 2, 4, 0); finish_run();
    check_st(64'h6780, 4, "R4");
    for (int i = 0; i < 3; i++) chk(cmd_tr[i], 0, "R4", "cmd NOP");
    chk(addr_tr[0], (2 << COL_W) | 4, "R13", "row,col in T1");
  endtask

  task automatic t_disabled();
    cfg_en = 0; cfg_cond = 2'b11; cfg_len = 1;
    do_reset(); issue(1, 1, 5, 0, 0); issue(0, 2, 1, 1, 1); finish_run();
    check_st(64'h123456780, 9, "R5");
  endtask

  task automatic t_one_idle();
    cfg_en = 1; cfg_cond = 2'b01; cfg_len = 0;
    do_reset(); issue(1, 1, 5, 0, 0); issue(0, 2, 1, 1, 0); finish_run();
    check_st(64'h1234596780, 10, "R6");
    chk(cmd_tr[5], 0, "R6", "cmd in Ti");
    chk(busy_tr[5], 0, "R9", "busy in last Ti");
  endtask

  task automatic t_two_idle();
    logic [10:0] eb;
    eb = 11'b11110101100;
    cfg_en = 1; cfg_cond = 2'b01; cfg_len = 1;
    do_reset(); issue(1, 1, 5, 0, 0); issue(0, 2, 1, 1, 0); finish_run();
    check_st(64'h12345996780, 11, "R7");
    for (int i = 0; i < 11; i++) chk(busy_tr[i], eb[10 - i], "R9", $sformatf("busy[%0d]", i));
  endtask

  task automatic t_cond_write();
    cfg_en = 1; cfg_cond = 2'b10; cfg_len = 0;
    do_reset(); issue(0, 1, 0, 0, 0); issue(0, 1, 0, 1, 1); finish_run();
    check_st(64'h67896780, 8, "R8");
    cfg_cond = 2'b11;
    do_reset(); issue(0, 1, 0, 0, 0); issue(0, 1, 0, 1, 0); finish_run();
    check_st(64'h6786780, 7, "R8");
  endtask

  task automatic t_normal_cond();
    cfg_en = 0; cfg_cond = 2'b01; cfg_len = 0;
    do_reset(); issue(0, 1, 0, 0, 0); issue(0, 4, 0, 1, 0); finish_run();
    check_st(64'h67896780, 8, "R12");
  endtask

  task automatic t_cfg_sample();
    cfg_en = 1; cfg_cond = 2'b01; cfg_len = 1;
    do_reset(); issue(1, 1, 5, 0, 0);
    fork
      issue(0, 2, 1, 1, 0);
      begin
        logic seen;
        seen = 1'b0;
        while (!seen) begin @(negedge clk); #1; seen = (st_code == 4'd9); end
        cfg_len = 0; cfg_en = 0; cfg_cond = 2'b00;
      end
    join
    finish_run();
    check_st(64'h12345996780, 11, "R10");
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_new_row();
    t_same_row();
    t_normal();
    t_disabled();
    t_one_idle();
    t_two_idle();
    t_cond_write();
    t_normal_cond();
    t_cfg_sample();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule